// File: doc/BRIEF.md
# Debug Watchpoint Comparator Bank

This block sits beside a processor's memory-access bus and holds a small set of programmable comparator units. Each unit stores an address pattern, a data pattern and two access attributes (transfer direction and transfer size), with a don't-care mask over the address and data patterns and a separate enable for each attribute. Every cycle the live bus transfer is tested against every enabled unit. A hit is reported as a one-cycle pulse that carries the index of the lowest-numbered unit that hit.

Each unit runs in one of two modes. In watch mode a hit only produces the pulse, which downstream trace logic turns into a message. The core keeps running. In break mode a hit also raises a halt request. The request stays up until the debug side acknowledges it, so code held in read-only storage can be stopped without being patched. A small register port programs the units. A shared status word keeps one sticky hit bit per unit, and software clears each bit by writing a one to it.

Register address `cfg_addr` = {unit[4:3], reg[2:0]}. The register codes are: 0 address pattern, 1 address mask, 2 data pattern, 3 data mask, 4 control. Unit field 3 with register 0 is the status word.

Top module: `dbg_watch_bank`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `hit_pulse` and `halt_req` are 0, `hit_idx` is 0, and every register and the status word read 0.
- R2: A write with `cfg_wr` high to unit u < N_UNITS and register code 0..4 is visible on `cfg_rdata` from the next cycle. Control keeps only bits [6:0]. Codes 5..7, units ≥ N_UNITS other than the status word, and unit 3 registers 1..7 read 0 and ignore writes.
- R3: Address match: a bit set to 1 in the address mask makes that address bit don't-care. Every other bit of `bus_addr` must equal the address pattern.
- R4: Data match uses the data pattern and data mask on `bus_data` under the same rule as R3.
- R5: Control bit 2 enables the direction check. When it is set, `bus_write` must equal control bit 3 (1 = write).
- R6: Control bit 4 enables the size check. When it is set, `bus_size` must equal control bits [6:5].
- R7: A unit can hit only when control bit 0 (enable) is 1 and `bus_valid` is 1. An enabled unit with both masks all ones and both attribute checks off hits on every valid transfer.
- R8: One cycle after a transfer on which at least one unit hits, `hit_pulse` is 1 for exactly that cycle and `hit_idx` holds the lowest index among the units that hit. Otherwise `hit_pulse` is 0 and `hit_idx` is 0.
- R9: A hit by a unit whose control bit 1 is 0 (watch mode) never sets `halt_req`.
- R10: A hit by a unit whose control bit 1 is 1 (break mode) sets `halt_req` on the next cycle. It stays set until `dbg_ack` is seen high on a clock edge with no new break-mode hit. A break hit on the same edge as `dbg_ack` keeps it set.
- R11: Status bit u sets on any hit by unit u. A write to the status word clears every bit that is 1 in `cfg_wdata`. A hit on the same cycle as the clear leaves the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address {unit, reg} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, combinational from `cfg_addr` |
| bus_valid | input | 1 | Live bus transfer is valid this cycle |
| bus_addr | input | ADDR_W | Transfer address |
| bus_data | input | DATA_W | Transfer data |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Transfer size code |
| dbg_ack | input | 1 | Debug side acknowledges the halt |
| hit_pulse | output | 1 | One-cycle hit event |
| hit_idx | output | IDX_W | Lowest hitting unit index |
| halt_req | output | 1 | Held halt request |

## Verification
The bench programs three units so that all three, two, or only the highest-numbered one hit the same transfer. A wrong priority order would report the wrong `hit_idx` in these cases. It checks that mask bits set to one free exactly those bits, so a reversed mask polarity would hit on the wrong addresses. It also turns the direction and size checks on and off independently, and an inverted attribute enable would block transfers that should hit. It lands `dbg_ack` on the same cycle as a new break hit and a status clear on the same cycle as a new hit, so a design that gives the clear priority would drop the halt or lose the sticky bit. Writes to unused codes and units are read back, and a loose decoder would show stray data there.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;

  localparam int unsigned REG_W       = 32;
  localparam int unsigned CTRL_W      = 7;
  localparam int unsigned SLOT_AW     = 2;
  localparam int unsigned REG_AW      = 3;
  localparam int unsigned CFG_AW      = SLOT_AW + REG_AW;
  localparam int unsigned STATUS_SLOT = 3;

  typedef enum logic [REG_AW-1:0] {
    RG_APAT = 3'd0,
    RG_AMSK = 3'd1,
    RG_DPAT = 3'd2,
    RG_DMSK = 3'd3,
    RG_CTRL = 3'd4
  } reg_sel_e;

  // bit 0 enable, bit 1 halt mode, bit 2 dir check, bit 3 dir value,
  // bit 4 size check, bits 6:5 size value
  typedef struct packed {
    logic [1:0] size_val;
    logic       size_chk;
    logic       dir_val;
    logic       dir_chk;
    logic       halt_mode;
    logic       enable;
  } wctrl_t;

  typedef struct packed {
    logic [REG_W-1:0] apat;
    logic [REG_W-1:0] amsk;
    logic [REG_W-1:0] dpat;
    logic [REG_W-1:0] dmsk;
    wctrl_t           ctl;
  } wslot_t;

  // mask bit 1 = bit ignored
  function automatic logic field_hit(logic [REG_W-1:0] live,
                                     logic [REG_W-1:0] pat,
                                     logic [REG_W-1:0] msk);
    return ((live ^ pat) & ~msk) == '0;
  endfunction

  function automatic logic attr_hit(logic chk, logic [1:0] live, logic [1:0] want);
    return !chk || (live == want);
  endfunction

endpackage

// File: rtl/dbg_watch_slot.sv
module dbg_watch_slot
  import dbg_watch_pkg::*;
#(
  parameter int unsigned SLOT_ID = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  output wslot_t            cfg_q,
  output logic [REG_W-1:0]  rd_word
);

  logic [SLOT_AW-1:0] sel_slot;
  logic [REG_AW-1:0]  sel_reg;
  logic               mine;

  assign sel_slot = cfg_addr[CFG_AW-1:REG_AW];
  assign sel_reg  = cfg_addr[REG_AW-1:0];
  assign mine     = (sel_slot == SLOT_AW'(SLOT_ID));

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_wr && mine) begin
      case (reg_sel_e'(sel_reg))
        RG_APAT: cfg_q.apat <= cfg_wdata;
        RG_AMSK: cfg_q.amsk <= cfg_wdata;
        RG_DPAT: cfg_q.dpat <= cfg_wdata;
        RG_DMSK: cfg_q.dmsk <= cfg_wdata;
        RG_CTRL: cfg_q.ctl  <= wctrl_t'(cfg_wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(sel_reg))
      RG_APAT: rd_word = cfg_q.apat;
      RG_AMSK: rd_word = cfg_q.amsk;
      RG_DPAT: rd_word = cfg_q.dpat;
      RG_DMSK: rd_word = cfg_q.dmsk;
      RG_CTRL: rd_word = REG_W'(cfg_q.ctl);
      default: rd_word = '0;
    endcase
  end

endmodule

// File: rtl/dbg_watch_cmp.sv
module dbg_watch_cmp
  import dbg_watch_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  wslot_t            cfg,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  output logic              hit
);

  logic [REG_W-1:0] a_live;
  logic [REG_W-1:0] d_live;
  logic             a_ok;
  logic             d_ok;
  logic             dir_ok;
  logic             size_ok;

  assign a_live  = REG_W'(bus_addr);
  assign d_live  = REG_W'(bus_data);
  assign a_ok    = field_hit(a_live, cfg.apat, cfg.amsk);
  assign d_ok    = field_hit(d_live, cfg.dpat, cfg.dmsk);
  assign dir_ok  = attr_hit(cfg.ctl.dir_chk, {1'b0, bus_write}, {1'b0, cfg.ctl.dir_val});
  assign size_ok = attr_hit(cfg.ctl.size_chk, bus_size, cfg.ctl.size_val);
  assign hit     = cfg.ctl.enable && bus_valid && a_ok && d_ok && dir_ok && size_ok;

endmodule

// File: rtl/dbg_watch_pick.sv
module dbg_watch_pick #(
  parameter int unsigned N     = 2,
  parameter int unsigned IDX_W = 1
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/dbg_watch_bank.sv
module dbg_watch_bank
  import dbg_watch_pkg::*;
#(
  parameter int unsigned N_UNITS = 2,   // 1..3
  parameter int unsigned ADDR_W  = 32,  // <= 32
  parameter int unsigned DATA_W  = 32,  // <= 32
  localparam int unsigned IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [4:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_write,
  input  logic [1:0]        bus_size,
  input  logic              dbg_ack,
  output logic              hit_pulse,
  output logic [IDX_W-1:0]  hit_idx,
  output logic              halt_req
);

  wslot_t           slot_cfg [N_UNITS];
  logic [REG_W-1:0] slot_rd  [N_UNITS];
  logic [N_UNITS-1:0] hits;
  logic [N_UNITS-1:0] brk_sel;
  logic [N_UNITS-1:0] sticky_q;
  logic [N_UNITS-1:0] sticky_clr;
  logic               any_hit;
  logic               any_break;
  logic [IDX_W-1:0]   first_idx;
  logic               status_wr;
  logic [SLOT_AW-1:0] rd_slot;
  logic [REG_AW-1:0]  rd_reg;

  for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
    dbg_watch_slot #(.SLOT_ID(g)) u_slot (
      .clk      (clk),
      .rst      (rst),
      .cfg_wr   (cfg_wr),
      .cfg_addr (cfg_addr),
      .cfg_wdata(cfg_wdata),
      .cfg_q    (slot_cfg[g]),
      .rd_word  (slot_rd[g])
    );

    dbg_watch_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmp (
      .cfg      (slot_cfg[g]),
      .bus_valid(bus_valid),
      .bus_addr (bus_addr),
      .bus_data (bus_data),
      .bus_write(bus_write),
      .bus_size (bus_size),
      .hit      (hits[g])
    );

    assign brk_sel[g] = slot_cfg[g].ctl.halt_mode;
  end

  dbg_watch_pick #(.N(N_UNITS), .IDX_W(IDX_W)) u_pick (
    .hits(hits),
    .any (any_hit),
    .idx (first_idx)
  );

  assign any_break  = |(hits & brk_sel);
  assign rd_slot    = cfg_addr[CFG_AW-1:REG_AW];
  assign rd_reg     = cfg_addr[REG_AW-1:0];
  assign status_wr  = cfg_wr && (rd_slot == SLOT_AW'(STATUS_SLOT)) && (rd_reg == '0);
  assign sticky_clr = status_wr ? cfg_wdata[N_UNITS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_pulse <= 1'b0;
      hit_idx   <= '0;
      halt_req  <= 1'b0;
      sticky_q  <= '0;
    end else begin
      hit_pulse <= any_hit;
      hit_idx   <= first_idx;
      halt_req  <= any_break || (halt_req && !dbg_ack);
      sticky_q  <= (sticky_q & ~sticky_clr) | hits;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if ((rd_slot == SLOT_AW'(STATUS_SLOT)) && (rd_reg == '0)) begin
      cfg_rdata = REG_W'(sticky_q);
    end else begin
      for (int i = 0; i < N_UNITS; i++) begin
        if (rd_slot == SLOT_AW'(i)) cfg_rdata = slot_rd[i];
      end
    end
  end

endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk #(
  parameter int unsigned N     = 2,
  parameter int unsigned IDX_W = 1
) (
  input logic             clk,
  input logic             rst,
  input logic             bus_valid,
  input logic             dbg_ack,
  input logic             hit_pulse,
  input logic [IDX_W-1:0] hit_idx,
  input logic             halt_req,
  input logic             any_hit,
  input logic             any_break,
  input logic [N-1:0]     sticky
);

  // R10: held until acknowledged
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (rst)
    halt_req && !dbg_ack |=> halt_req);

  // R10: break hit raises the request next cycle
  p_break_sets_r10: assert property (@(posedge clk) disable iff (rst)
    any_break |=> halt_req);

  // R9: without a break hit the request never rises
  p_watch_nohalt_r9: assert property (@(posedge clk) disable iff (rst)
    !halt_req && !any_break |=> !halt_req);

  // R7: idle bus produces no pulse
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> !hit_pulse);

  // R8: pulse follows a hit in the previous cycle
  p_pulse_cause_r8: assert property (@(posedge clk) disable iff (rst)
    any_hit |=> hit_pulse);

  // R8: no pulse, index zero
  p_idx_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !hit_pulse |-> hit_idx == '0);

  // R11: the reported unit has its sticky bit set
  p_sticky_match_r11: assert property (@(posedge clk) disable iff (rst)
    hit_pulse |-> sticky[hit_idx]);

endmodule

bind dbg_watch_bank dbg_watch_chk #(.N(N_UNITS), .IDX_W(IDX_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .bus_valid(bus_valid),
  .dbg_ack  (dbg_ack),
  .hit_pulse(hit_pulse),
  .hit_idx  (hit_idx),
  .halt_req (halt_req),
  .any_hit  (any_hit),
  .any_break(any_break),
  .sticky   (sticky_q)
);

// File: tb/dbg_watch_bank_tb_top.sv
module dbg_watch_bank_tb_top;

  localparam int NU = 3;
  localparam int IW = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_data = '0;
  logic        bus_write = 1'b0;
  logic [1:0]  bus_size = '0;
  logic        dbg_ack = 1'b0;
  logic        hit_pulse;
  logic [IW-1:0] hit_idx;
  logic        halt_req;

  always #4 clk = ~clk;

  dbg_watch_bank #(.N_UNITS(NU), .ADDR_W(32), .DATA_W(32)) dut_i (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_valid(bus_valid),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_write(bus_write),
    .bus_size(bus_size), .dbg_ack(dbg_ack), .hit_pulse(hit_pulse),
    .hit_idx(hit_idx), .halt_req(halt_req)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_apat [NU];
  logic [31:0] m_amsk [NU];
  logic [31:0] m_dpat [NU];
  logic [31:0] m_dmsk [NU];
  logic [6:0]  m_ctl  [NU];
  logic        e_hit, e_halt;
  int          e_idx;
  logic [NU-1:0] e_sticky;

  function automatic bit bits_agree(logic [31:0] live, logic [31:0] pat, logic [31:0] msk);
    for (int b = 0; b < 32; b++) begin
      if (msk[b] == 1'b0 && live[b] != pat[b]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit unit_hits(int u);
    bit ok;
    ok = m_ctl[u][0] && bus_valid;
    ok = ok && bits_agree(bus_addr, m_apat[u], m_amsk[u]);
    ok = ok && bits_agree(bus_data, m_dpat[u], m_dmsk[u]);
    if (m_ctl[u][2] && (bus_write != m_ctl[u][3])) ok = 1'b0;
    if (m_ctl[u][4] && (bus_size != m_ctl[u][6:5])) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [31:0] exp_read(logic [4:0] a);
    int s, r;
    s = int'(a[4:3]);
    r = int'(a[2:0]);
    if (s == 3 && r == 0) return 32'(e_sticky);
    if (s >= NU) return 32'h0;
    case (r)
      0: return m_apat[s];
      1: return m_amsk[s];
      2: return m_dpat[s];
      3: return m_dmsk[s];
      4: return {25'h0, m_ctl[s]};
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < NU; u++) begin
        m_apat[u] = '0; m_amsk[u] = '0; m_dpat[u] = '0; m_dmsk[u] = '0; m_ctl[u] = '0;
      end
      e_hit = 1'b0; e_idx = 0; e_halt = 1'b0; e_sticky = '0;
    end else begin
      bit brk;
      int first;
      bit h [NU];
      brk = 1'b0;
      first = -1;
      for (int u = 0; u < NU; u++) begin
        h[u] = unit_hits(u);
        if (h[u] && first < 0) first = u;
        if (h[u] && m_ctl[u][1]) brk = 1'b1;
      end
      e_hit  = (first >= 0);
      e_idx  = (first >= 0) ? first : 0;
      e_halt = brk || (e_halt && !dbg_ack);
      for (int u = 0; u < NU; u++) begin
        bit clr;
        clr = cfg_wr && cfg_addr == 5'b11_000 && cfg_wdata[u];
        e_sticky[u] = h[u] || (e_sticky[u] && !clr);
      end
      if (cfg_wr && int'(cfg_addr[4:3]) < NU) begin
        case (int'(cfg_addr[2:0]))
          0: m_apat[cfg_addr[4:3]] = cfg_wdata;
          1: m_amsk[cfg_addr[4:3]] = cfg_wdata;
          2: m_dpat[cfg_addr[4:3]] = cfg_wdata;
          3: m_dmsk[cfg_addr[4:3]] = cfg_wdata;
          4: m_ctl[cfg_addr[4:3]]  = cfg_wdata[6:0];
          default: ;
        endcase
      end
    end
  end

  // ---------------- checking ----------------
  int    n_chk = 0;
  int    n_bad = 0;
  int    n_cyc = 0;
  string cur_req = "R1";

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    chk("hit_pulse", 32'(hit_pulse), 32'(e_hit));
    chk("hit_idx",   32'(hit_idx),   32'(e_idx));
    chk("halt_req",  32'(halt_req),  32'(e_halt));
    chk("cfg_rdata", cfg_rdata,      exp_read(cfg_addr));
  end

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 50000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=%0d exp=done", n_cyc);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic cyc(logic wr, logic [4:0] ca, logic [31:0] cd, logic v,
                     logic [31:0] ba, logic [31:0] bd, logic bw, logic [1:0] bs, logic ack);
    @(negedge clk);
    cfg_wr = wr; cfg_addr = ca; cfg_wdata = cd;
    bus_valid = v; bus_addr = ba; bus_data = bd; bus_write = bw; bus_size = bs;
    dbg_ack = ack;
  endtask

  task automatic put_cfg(int u, int r, logic [31:0] d);
    cyc(1'b1, 5'(u * 8 + r), d, 1'b0, '0, '0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic put_bus(logic [31:0] a, logic [31:0] d, logic w, logic [1:0] s);
    cyc(1'b0, cfg_addr, '0, 1'b1, a, d, w, s, 1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, cfg_addr, '0, 1'b0, '0, '0, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic rd(int u, int r);
    cyc(1'b0, 5'(u * 8 + r), '0, 1'b0, '0, '0, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(2);
    for (int r = 0; r < 5; r++) rd(1, r);
    rd(3, 0);

    // R2: write and read back, truncation, unused locations
    cur_req = "R2";
    put_cfg(0, 0, 32'h0000_1000);
    put_cfg(0, 1, 32'h0000_000F);
    put_cfg(0, 2, 32'h1234_5678);
    put_cfg(0, 3, 32'hFFFF_FFFF);
    put_cfg(0, 4, 32'hFFFF_FF81);
    put_cfg(0, 6, 32'hDEAD_BEEF);
    put_cfg(3, 1, 32'hAAAA_AAAA);
    for (int r = 0; r < 8; r++) rd(0, r);
    rd(3, 1);
    rd(3, 5);

    // R3: address under mask
    cur_req = "R3";
    rd(3, 0);
    put_bus(32'h0000_1004, 32'h0, 1'b0, 2'd0);
    put_bus(32'h0000_1010, 32'h0, 1'b0, 2'd0);
    put_bus(32'h0000_100F, 32'h0, 1'b1, 2'd3);
    put_bus(32'h8000_1000, 32'h0, 1'b0, 2'd0);
    idle(2);

    // R4: data under mask
    cur_req = "R4";
    put_cfg(1, 1, 32'hFFFF_FFFF);
    put_cfg(1, 2, 32'hCAFE_0000);
    put_cfg(1, 3, 32'h0000_FFFF);
    put_cfg(1, 4, 32'h0000_0001);
    rd(3, 0);
    put_bus(32'h0000_2000, 32'hCAFE_1234, 1'b0, 2'd0);
    put_bus(32'h0000_2000, 32'hCAFF_0000, 1'b0, 2'd0);
    put_bus(32'h0000_2000, 32'hCAFE_FFFF, 1'b1, 2'd1);
    idle(2);

    // R5: direction check
    cur_req = "R5";
    put_cfg(2, 1, 32'hFFFF_FFFF);
    put_cfg(2, 3, 32'hFFFF_FFFF);
    put_cfg(2, 4, 32'h0000_000D);
    rd(3, 0);
    put_bus(32'h0000_3000, 32'h0, 1'b1, 2'd0);
    put_bus(32'h0000_3000, 32'h0, 1'b0, 2'd0);
    idle(1);

    // R6: size check
    cur_req = "R6";
    put_cfg(2, 4, 32'h0000_0051);
    rd(3, 0);
    put_bus(32'h0000_3000, 32'h0, 1'b0, 2'd2);
    put_bus(32'h0000_3000, 32'h0, 1'b1, 2'd1);
    put_bus(32'h0000_3000, 32'h0, 1'b1, 2'd2);
    idle(1);

    // R7: enable and valid qualify, all-masked unit hits anything
    cur_req = "R7";
    put_cfg(2, 4, 32'h0000_0000);
    rd(3, 0);
    put_bus(32'h0000_3000, 32'h0, 1'b0, 2'd0);
    put_cfg(2, 4, 32'h0000_0001);
    rd(3, 0);
    cyc(1'b0, cfg_addr, '0, 1'b0, 32'h0000_1004, 32'hCAFE_0000, 1'b0, 2'd0, 1'b0);
    put_bus(32'h7654_3210, 32'h0BAD_F00D, 1'b1, 2'd3);
    idle(1);

    // R8: lowest index wins, back-to-back pulses
    cur_req = "R8";
    put_bus(32'h0000_1004, 32'hCAFE_0000, 1'b0, 2'd0);
    put_bus(32'h0000_5000, 32'hCAFE_0000, 1'b0, 2'd0);
    put_bus(32'h0000_5000, 32'h0000_0000, 1'b0, 2'd0);
    idle(1);
    put_bus(32'h0000_5000, 32'hCAFE_0000, 1'b0, 2'd0);
    idle(2);

    // R9: watch-mode hits never halt
    cur_req = "R9";
    for (int i = 0; i < 4; i++) put_bus(32'h0000_1000 + i, 32'hCAFE_0000, 1'b0, 2'd0);
    idle(2);

    // R10: break mode, hold, acknowledge, ack colliding with new hit
    cur_req = "R10";
    put_cfg(1, 4, 32'h0000_0003);
    put_bus(32'h0000_5000, 32'hCAFE_0000, 1'b0, 2'd0);
    idle(3);
    cyc(1'b0, cfg_addr, '0, 1'b0, '0, '0, 1'b0, 2'd0, 1'b1);
    idle(2);
    put_bus(32'h0000_5000, 32'hCAFE_0000, 1'b0, 2'd0);
    idle(1);
    cyc(1'b0, cfg_addr, '0, 1'b1, 32'h0000_5000, 32'hCAFE_0000, 1'b0, 2'd0, 1'b1);
    idle(2);
    cyc(1'b0, cfg_addr, '0, 1'b0, '0, '0, 1'b0, 2'd0, 1'b1);
    idle(2);
    put_bus(32'h0000_5000, 32'h0000_0000, 1'b0, 2'd0);
    idle(2);

    // R11: sticky status, write-one-clear, set wins
    cur_req = "R11";
    rd(3, 0);
    put_bus(32'h0000_1004, 32'hCAFE_0000, 1'b0, 2'd0);
    put_cfg(3, 0, 32'h0000_0001);
    rd(3, 0);
    cyc(1'b1, 5'b11_000, 32'h0000_0007, 1'b1, 32'h0000_5000, 32'h0, 1'b0, 2'd0, 1'b0);
    rd(3, 0);
    put_cfg(3, 0, 32'hFFFF_FFFF);
    rd(3, 0);
    idle(2);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule